// File: doc/BRIEF.md
# Indexed Performance Counter Unit

The block is a bank of event counters that software reaches through a small register window. Each counter watches one of several countable condition lines, selected by a condition code in that counter's configuration register. One global enable starts or stops every counter at the same time. Code 0 is a condition that never fires, so writing 0 into a counter's configuration stops that counter. There is no separate per-counter run bit.

The counters are wider than 32 bits, 32 + 16·s bits. Software selects a counter by writing a counter-select register. The configuration, count-low, count-high and snapshot operations then all act on that counter. A snapshot command copies the whole selected counter into a pair of read-only snapshot registers on one clock edge. The two halves can then be read without a carry between them. Read-only build registers describe the bank. A second select register picks a condition, and two name registers then return that condition's 8-character ASCII label.

The register port has a read-response state machine with two states. BUS_IDLE moves to BUS_RESP on a read strobe (transition *accept*). BUS_RESP stays in BUS_RESP on a further strobe (transition *chain*). BUS_RESP returns to BUS_IDLE when there is no strobe (transition *retire*). Register map (`reg_addr`):
- 0 CTRL: bit 0 is the global enable. Bit 1 is the snapshot command and reads 0. Bits 31:16 are a stored field.
- 1 CNT_SEL, 2 CNT_CFG, 3 CNT_LO, 4 CNT_HI.
- 5 SNAP_LO and 6 SNAP_HI, both read-only.
- 7 BANK_INFO and 8 COND_INFO, both read-only.
- 9 COND_SEL, 10 NAME_A, 11 NAME_B.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset the global enable, CTRL, both select registers, every counter and the snapshot are zero, and `reg_rvalid` is 0.
- R2: A counter adds exactly 1 on each clock edge where the global enable is 1 and the condition line picked by its code is high. Code 0 never counts, even if line 0 is high.
- R3: CTRL bit 0 starts and stops all counters. While it is 0, condition pulses change no counter. CTRL bits 31:16 are stored and read back. Bit 1 always reads as 0.
- R4: CNT_CFG, CNT_LO, CNT_HI and the snapshot act only on the counter named by CNT_SEL. Other counters keep their value and code.
- R5: A CTRL write with bit 1 set copies the selected counter into the snapshot on that edge. SNAP_LO returns bits 31:0 and SNAP_HI returns the upper bits, zero-extended. The snapshot then stays fixed while the counter keeps running.
- R6: Writing CNT_LO replaces bits 31:0 and writing CNT_HI replaces the upper bits of the selected counter. A count-register write takes priority over an increment on the same edge.
- R7: BANK_INFO reads bit 31 = 1, bits 11:8 = s, and bits 7:0 = number of counters (0x8000_0104 by default). COND_INFO reads bit 31 = 1 and bits 7:0 = number of conditions (0x8000_0008).
- R8: For a valid COND_SEL value j, NAME_A reads 0x5F444E43 ("CND_", first character in the low byte). NAME_B holds the upper hex digit of j in bits 7:0, the lower hex digit in bits 15:8, and zero above.
- R9: If CNT_SEL is at or above the counter count, per-counter reads return 0, and per-counter writes and snapshots change nothing. If COND_SEL is out of range, both name registers read 0.
- R10: `reg_rvalid` is 1 exactly in the cycle after a cycle with `reg_rd` high. `reg_rdata` then holds the register value from before that edge. Back-to-back reads are served on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response valid |
| cond_pulse | input | NUM_COND | One event pulse line per condition; line 0 is ignored |

## Verification
The counting path is driven with three condition patterns:
- A single line held high, which separates correct routing by code from a counter that counts any line.
- Several lines high at once, including line 0, which shows that one counter follows its own code while a code-0 counter stays still.
- Pulses with the global enable off, which isolates the enable gating from the code gating.

A preset just below a 32-bit wrap, followed by counting across it, shows whether the carry reaches the upper half. A snapshot taken mid-run and then read after further counting shows whether the captured copy is separate from the live counter. A count write made while its condition is high separates write priority from a late increment.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam logic [3:0] A_CTRL      = 4'd0;
    localparam logic [3:0] A_CNT_SEL   = 4'd1;
    localparam logic [3:0] A_CNT_CFG   = 4'd2;
    localparam logic [3:0] A_CNT_LO    = 4'd3;
    localparam logic [3:0] A_CNT_HI    = 4'd4;
    localparam logic [3:0] A_SNAP_LO   = 4'd5;
    localparam logic [3:0] A_SNAP_HI   = 4'd6;
    localparam logic [3:0] A_BANK_INFO = 4'd7;
    localparam logic [3:0] A_COND_INFO = 4'd8;
    localparam logic [3:0] A_COND_SEL  = 4'd9;
    localparam logic [3:0] A_NAME_A    = 4'd10;
    localparam logic [3:0] A_NAME_B    = 4'd11;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/pcu_bus_fsm.sv
module pcu_bus_fsm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd,
    input  logic [31:0] rd_value,
    output logic [31:0] rdata,
    output logic        rvalid
);
    import pcu_pkg::*;

    bus_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    // transitions: accept, chain, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE: state_nx = rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nx = rd ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rvalid = (state == BUS_RESP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_value;
    end

    assert_resp_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    assert_no_resp_without_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

endmodule

// File: rtl/pcu_cond_name.sv
module pcu_cond_name #(
    parameter int NUM_COND = 8
) (
    input  logic [7:0]  cond_sel,
    output logic [31:0] name_a,
    output logic [31:0] name_b
);
    import pcu_pkg::*;

    localparam logic [7:0] NUM_COND_B = 8'(NUM_COND);

    always_comb begin
        if (cond_sel < NUM_COND_B) begin
            name_a = {8'h5F, 8'h44, 8'h4E, 8'h43};
            name_b = {16'h0000, hex_char(cond_sel[3:0]), hex_char(cond_sel[7:4])};
        end else begin
            name_a = '0;
            name_b = '0;
        end
    end

endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int CNT_W    = 48,
    parameter int NUM_COND = 8,
    parameter int CODE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                glob_en,
    input  logic [NUM_COND-1:0] cond_vec,
    input  logic                cfg_we,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [31:0]         wdata,
    output logic [CODE_W-1:0]   code,
    output logic [CNT_W-1:0]    count
);
    localparam int HI_W = CNT_W - 32;

    logic hit;

    always_comb begin
        hit = glob_en && (code != '0) && cond_vec[code];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      code <= '0;
        else if (cfg_we) code <= wdata[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (lo_we || hi_we) begin
            if (lo_we) count[31:0]      <= wdata;
            if (hi_we) count[CNT_W-1:32] <= wdata[HI_W-1:0];
        end else if (hit) begin
            count <= count + CNT_W'(1);
        end
    end

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_we && !hi_we) |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));
    assert_code0_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0 && !lo_we && !hi_we) |=> $stable(count));
    assert_stopped_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !lo_we && !hi_we) |=> $stable(count));

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
    parameter int NUM_CNT  = 4,
    parameter int SIZE_S   = 1,
    parameter int NUM_COND = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                reg_rvalid,
    input  logic [NUM_COND-1:0] cond_pulse
);
    import pcu_pkg::*;

    localparam int CNT_W  = 32 + 16 * SIZE_S;
    localparam int HI_W   = CNT_W - 32;
    localparam int CODE_W = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;
    localparam int SELI_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam logic [7:0] NUM_CNT_B = 8'(NUM_CNT);

    logic              glob_en;
    logic [15:0]       ctrl_hi;
    logic [7:0]        cnt_sel;
    logic [7:0]        cond_sel;
    logic [CNT_W-1:0]  snap;
    logic [CNT_W-1:0]  cnt_val [NUM_CNT];
    logic [CODE_W-1:0] code_val [NUM_CNT];
    logic              sel_ok;
    logic [CNT_W-1:0]  sel_cnt;
    logic [CODE_W-1:0] sel_code;
    logic [31:0]       name_a, name_b, rd_value;
    logic              wr_ctrl, wr_cfg, wr_lo, wr_hi, snap_cmd;

    always_comb begin
        sel_ok   = (cnt_sel < NUM_CNT_B);
        sel_cnt  = sel_ok ? cnt_val[cnt_sel[SELI_W-1:0]]  : '0;
        sel_code = sel_ok ? code_val[cnt_sel[SELI_W-1:0]] : '0;
        wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
        wr_cfg   = reg_wr && (reg_addr == A_CNT_CFG);
        wr_lo    = reg_wr && (reg_addr == A_CNT_LO);
        wr_hi    = reg_wr && (reg_addr == A_CNT_HI);
        snap_cmd = wr_ctrl && reg_wdata[1] && sel_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en  <= 1'b0;
            ctrl_hi  <= '0;
            cnt_sel  <= '0;
            cond_sel <= '0;
            snap     <= '0;
        end else begin
            if (wr_ctrl) begin
                glob_en <= reg_wdata[0];
                ctrl_hi <= reg_wdata[31:16];
            end
            if (snap_cmd) snap <= sel_cnt;
            if (reg_wr && reg_addr == A_CNT_SEL)  cnt_sel  <= reg_wdata[7:0];
            if (reg_wr && reg_addr == A_COND_SEL) cond_sel <= reg_wdata[7:0];
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic mine;
        always_comb mine = sel_ok && (cnt_sel == 8'(g));
        pcu_counter #(.CNT_W(CNT_W), .NUM_COND(NUM_COND), .CODE_W(CODE_W)) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .glob_en  (glob_en),
            .cond_vec (cond_pulse),
            .cfg_we   (wr_cfg && mine),
            .lo_we    (wr_lo && mine),
            .hi_we    (wr_hi && mine),
            .wdata    (reg_wdata),
            .code     (code_val[g]),
            .count    (cnt_val[g])
        );
    end

    pcu_cond_name #(.NUM_COND(NUM_COND)) u_names (
        .cond_sel (cond_sel),
        .name_a   (name_a),
        .name_b   (name_b)
    );

    always_comb begin
        rd_value = '0;
        unique case (reg_addr)
            A_CTRL:      rd_value = {ctrl_hi, 15'h0, glob_en};
            A_CNT_SEL:   rd_value = {24'h0, cnt_sel};
            A_CNT_CFG:   rd_value = 32'(sel_code);
            A_CNT_LO:    rd_value = sel_cnt[31:0];
            A_CNT_HI:    rd_value = 32'(sel_cnt[CNT_W-1:32]);
            A_SNAP_LO:   rd_value = snap[31:0];
            A_SNAP_HI:   rd_value = 32'(snap[CNT_W-1:32]);
            A_BANK_INFO: rd_value = {1'b1, 19'h0, 4'(SIZE_S), NUM_CNT_B};
            A_COND_INFO: rd_value = {1'b1, 23'h0, 8'(NUM_COND)};
            A_COND_SEL:  rd_value = {24'h0, cond_sel};
            A_NAME_A:    rd_value = name_a;
            A_NAME_B:    rd_value = name_b;
            default:     rd_value = '0;
        endcase
    end

    pcu_bus_fsm u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (reg_rd),
        .rd_value (rd_value),
        .rdata    (reg_rdata),
        .rvalid   (reg_rvalid)
    );

    assert_snap_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cmd |=> (snap == $past(sel_cnt)));
    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_cmd |=> $stable(snap));
    assert_oob_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && reg_wr) |=> (cnt_val[0] == $past(cnt_val[0]) || cnt_val[0] == $past(cnt_val[0]) + CNT_W'(1)));

    initial begin
        assert_width_R7: assert (HI_W >= 1 && HI_W <= 32);
    end

endmodule

// File: tb/perf_counter_unit_bench.sv
module perf_counter_unit_bench;
    import pcu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [7:0]  cond_pulse = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    perf_counter_unit u_perf_counter_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .cond_pulse(cond_pulse)
    );

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10: response with no read, actual %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] mask, input int n);
        @(negedge clk);
        cond_pulse = mask;
        repeat (n) @(negedge clk);
        cond_pulse = '0;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d responses missing, actual 0 expected %0d", exp_q.size(), exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (reg_rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rvalid actual %b expected 0", reg_rvalid);
        end
        rd(A_CTRL,    32'h0, "R1 ctrl");
        rd(A_CNT_SEL, 32'h0, "R1 cnt_sel");
        rd(A_CNT_LO,  32'h0, "R1 count");
        rd(A_SNAP_LO, 32'h0, "R1 snap");

        rd(A_BANK_INFO, 32'h8000_0104, "R7 bank info");
        rd(A_COND_INFO, 32'h8000_0008, "R7 cond info");

        wr(A_COND_SEL, 32'd5);
        rd(A_NAME_A, 32'h5F44_4E43, "R8 name a");
        rd(A_NAME_B, 32'h0000_3530, "R8 name b");
        wr(A_COND_SEL, 32'd9);
        rd(A_NAME_A, 32'h0, "R9 name oob");

        wr(A_CTRL, 32'hABCD_0001);
        rd(A_CTRL, 32'hABCD_0001, "R3 ctrl readback");
        wr(A_CTRL, 32'hABCD_0000);

        wr(A_CNT_SEL, 32'd0); wr(A_CNT_CFG, 32'd3);
        wr(A_CNT_SEL, 32'd1); wr(A_CNT_CFG, 32'd5);
        pulse(8'h28, 4);
        wr(A_CNT_SEL, 32'd0);
        rd(A_CNT_LO, 32'd0, "R3 disabled no count");

        wr(A_CTRL, 32'hABCD_0001);
        pulse(8'h29, 6);
        pulse(8'h08, 4);
        rd(A_CNT_LO, 32'd10, "R2 counter0 code3");
        wr(A_CNT_SEL, 32'd1);
        rd(A_CNT_LO, 32'd6, "R2 counter1 code5");
        rd(A_CNT_CFG, 32'd5, "R4 cfg per counter");
        wr(A_CNT_SEL, 32'd2);
        rd(A_CNT_LO, 32'd0, "R2 code0 never");

        // write priority: count write on an edge where the condition is high
        wr(A_CNT_SEL, 32'd0);
        @(negedge clk);
        cond_pulse = 8'h08; reg_wr = 1'b1; reg_addr = A_CNT_LO; reg_wdata = 32'd100;
        @(negedge clk);
        cond_pulse = '0; reg_wr = 1'b0;
        rd(A_CNT_LO, 32'd100, "R6 write beats increment");

        wr(A_CNT_LO, 32'hFFFF_FFF0);
        wr(A_CNT_HI, 32'h0000_00AB);
        pulse(8'h08, 20);
        wr(A_CTRL, 32'hABCD_0003);
        pulse(8'h08, 5);
        rd(A_SNAP_LO, 32'h0000_0004, "R5 snap lo");
        rd(A_SNAP_HI, 32'h0000_00AC, "R5 snap hi carry");
        rd(A_CNT_LO,  32'h0000_0009, "R5 counter runs on");
        rd(A_CNT_HI,  32'h0000_00AC, "R6 preset hi carry");
        rd(A_CTRL,    32'hABCD_0001, "R3 snap bit reads 0");
        wr(A_CNT_SEL, 32'd1);
        rd(A_CNT_LO, 32'd6, "R4 other counter untouched");

        wr(A_CNT_SEL, 32'd6);
        wr(A_CNT_LO, 32'd55);
        wr(A_CNT_CFG, 32'd2);
        wr(A_CTRL, 32'hABCD_0003);
        rd(A_CNT_LO, 32'd0, "R9 oob count read");
        rd(A_CNT_CFG, 32'd0, "R9 oob cfg read");
        rd(A_SNAP_LO, 32'h0000_0004, "R9 oob snapshot ignored");
        wr(A_CNT_SEL, 32'd0);
        rd(A_CNT_LO, 32'h0000_0009, "R9 oob write ignored");

        wr(A_CNT_SEL, 32'd1);
        wr(A_CNT_CFG, 32'd0);
        pulse(8'h20, 5);
        rd(A_CNT_LO, 32'd6, "R2 code0 stops counter");

        // back-to-back reads
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_CNT_SEL;
        exp_q.push_back(32'd1); tag_q.push_back("R10 first of pair");
        @(negedge clk);
        reg_addr = A_CNT_CFG;
        exp_q.push_back(32'd0); tag_q.push_back("R10 second of pair");
        @(negedge clk);
        reg_rd = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule